// File: doc/BRIEF.md
# Receive Descriptor Write-Back Engine

This block is the receive half of a descriptor-based Ethernet DMA. Frames arrive on a byte stream with valid/ready/last. At the start of each frame the engine checks the receive enable. If reception is allowed, it reads the descriptor at the current ring pointer over a simple request/grant memory master. The descriptor supplies an ownership flag, a wrap flag and a buffer address. The engine then stores the frame bytes into that buffer one byte lane at a time. When the frame ends, it writes the descriptor's status word back with the received length and steps the ring pointer.

A frame that is refused, too short, or that finds no descriptor owned by the engine is still fully consumed from the stream, so the upstream source never stalls on it. Only accepted frames update the counters for frames, bytes, broadcast frames and multicast frames. Every frame that ends in a status event raises one single-cycle pulse on `sts_set`, which the register block ORs into its status register. CRC checking and address filtering are not part of this block.

Top module: `rxwb_engine`

## Requirements
- R1: If `rx_en` is low when the first byte of a frame is offered, the whole frame is drained. No memory write takes place, no `sts_set` pulse is raised and no counter changes.
- R2: A frame of fewer than 12 bytes causes no descriptor write-back and leaves the pointer and counters unchanged. It pulses `sts_set` = 4'b0011. This holds even when the descriptor is not owned. A 12-byte frame is accepted.
- R3: The descriptor is read at `cur_desc`+0, +4 and +8. Bit 31 of word 0 means the engine owns it. Bit 15 of word 1 is the wrap flag. Word 2 is the buffer address. If the descriptor is not owned, a frame of 12 bytes or more is drained with no memory write and pulses `sts_set` = 4'b1100.
- R4: Byte i of a frame is written to buffer address + i. Each write carries a word-aligned address, exactly one byte enable (lane = address bits 1:0) and the byte on every lane. `mem_req` and its address stay stable until `mem_gnt`. No byte past the frame is written.
- R5: The write-back is one full-word write to `cur_desc`+0. Bits 31:16 hold the frame length plus 4, and bits 15:0 hold 16'h0300, which leaves bit 31 (ownership) clear.
- R6: After a write-back, `cur_desc` becomes the base if the wrap flag was set, and otherwise advances by 32. A `base_wr` pulse loads both the base and `cur_desc` from `base_addr`. After reset `cur_desc` is 0.
- R7: A frame whose first six bytes are all 8'hFF counts as broadcast. A frame is otherwise multicast when bit 0 of its first byte is 1, and unicast when that bit is 0. Each accepted frame increments at most one of `bcast_cnt` and `mcast_cnt`.
- R8: Each accepted frame adds 1 to `frame_cnt` and its length plus 4 to `byte_cnt`. All counters are 0 after reset.
- R9: An accepted frame pulses `sts_set` = 4'b0011 (bit 0 receive-done, bit 1 normal summary; bit 2 no-descriptor, bit 3 abnormal summary). There is exactly one pulse per frame, and no other value than 0, 4'b0011 or 4'b1100 ever appears.
- R10: `s_ready` is low whenever `mem_req` is high, so no byte is taken while a descriptor read or write is pending. It is also low in idle and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable, sampled at frame start |
| base_wr | input | 1 | Load ring base and current pointer |
| base_addr | input | ADDR_W | Ring base address |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Last byte of frame |
| s_ready | output | 1 | Stream byte accepted this cycle when high with valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Grant; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| cur_desc | output | ADDR_W | Current descriptor pointer |
| sts_set | output | 4 | One-cycle status event pulse |
| frame_cnt | output | CNT_W | Accepted frames |
| byte_cnt | output | CNT_W | Accepted bytes including 4 CRC bytes per frame |
| bcast_cnt | output | CNT_W | Accepted broadcast frames |
| mcast_cnt | output | CNT_W | Accepted multicast frames |

## Verification
`cur_desc` moves on the clock edge that grants the write-back. The counters and the `sts_set` pulse are registered one cycle later, so they appear on the same cycle as each other, one cycle after the pointer. The memory model grants every other cycle. After the last byte of a frame, the write-back therefore completes within about six cycles. The bench waits a fixed twelve cycles after the last byte before it samples the pointer, counters and memory. It collects every `sts_set` pulse at the falling edge during that window, so it checks both the value of the event and that exactly one was raised.

// File: rtl/rxwb_pkg.sv
// Shared types and constants for the receive descriptor write-back engine.
package rxwb_pkg;
    localparam int MIN_FRAME   = 12;
    localparam int CRC_BYTES   = 4;
    localparam int DESC_STRIDE = 32;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RD_CTL, ST_RD_SIZE, ST_RD_BUF,
        ST_RECV, ST_PUT, ST_DROP, ST_WRB, ST_FIN
    } rx_state_e;

    typedef enum logic [1:0] {
        RES_NONE, RES_OK, RES_RUNT, RES_NODESC
    } rx_result_e;
endpackage

// File: rtl/rxwb_classify.sv
// Frame destination classifier.
// Watches the first six accepted bytes of a frame and reports broadcast or
// multicast. Assumes start and beat are never high together and that the
// outputs are read only after at least six bytes (runts are not counted).
module rxwb_classify (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       beat,
    input  logic [7:0] data,
    output logic       is_bcast,
    output logic       is_mcast
);
    logic [2:0] idx_q;
    logic       all_ff_q;
    logic       grp_bit_q;

    // Track position within the address header and the two flags.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            idx_q     <= '0;
            all_ff_q  <= 1'b1;
            grp_bit_q <= 1'b0;
        end else if (beat && idx_q < 3'd6) begin
            idx_q <= idx_q + 3'd1;
            if (data != 8'hFF) all_ff_q <= 1'b0;
            if (idx_q == 3'd0) grp_bit_q <= data[0];
        end
    end

    // Broadcast wins; multicast is any group address that is not broadcast.
    always_comb begin
        is_bcast = all_ff_q && (idx_q == 3'd6);
        is_mcast = grp_bit_q && !is_bcast;
    end
endmodule

// File: rtl/rxwb_stats.sv
// Receive statistics counters.
// On each commit pulse adds one frame and its length plus CRC bytes, and
// bumps either the multicast or the broadcast count (multicast first).
module rxwb_stats #(
    parameter int LEN_W = 16,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             is_bcast,
    input  logic             is_mcast,
    output logic [CNT_W-1:0] frame_cnt,
    output logic [CNT_W-1:0] byte_cnt,
    output logic [CNT_W-1:0] bcast_cnt,
    output logic [CNT_W-1:0] mcast_cnt
);
    localparam logic [CNT_W-1:0] CRC_ADD = CNT_W'(rxwb_pkg::CRC_BYTES);

    // Accumulate counters for each committed frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_cnt <= '0;
            byte_cnt  <= '0;
            bcast_cnt <= '0;
            mcast_cnt <= '0;
        end else if (commit) begin
            frame_cnt <= frame_cnt + CNT_W'(1);
            byte_cnt  <= byte_cnt + CNT_W'(frame_len) + CRC_ADD;
            if (is_mcast)      mcast_cnt <= mcast_cnt + CNT_W'(1);
            else if (is_bcast) bcast_cnt <= bcast_cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/rxwb_engine.sv
// Receive descriptor write-back engine (top).
// Sequences descriptor fetch, byte-wise buffer fill, status write-back and
// ring pointer update for each frame on the byte stream. Assumes ADDR_W<=32,
// LEN_W<=16, and read data valid in the same cycle as mem_gnt.
module rxwb_engine
    import rxwb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic [31:0]       mem_rdata,
    output logic [ADDR_W-1:0] cur_desc,
    output logic [3:0]        sts_set,
    output logic [CNT_W-1:0]  frame_cnt,
    output logic [CNT_W-1:0]  byte_cnt,
    output logic [CNT_W-1:0]  bcast_cnt,
    output logic [CNT_W-1:0]  mcast_cnt
);
    localparam logic [LEN_W-1:0]  MIN_LEN  = LEN_W'(MIN_FRAME);
    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(DESC_STRIDE);
    localparam logic [3:0]        EV_DONE  = 4'b0011;
    localparam logic [3:0]        EV_NODSC = 4'b1100;

    rx_state_e         state_q;
    rx_result_e        res_q;
    logic [ADDR_W-1:0] base_q, cur_q, buf_q;
    logic              wrap_q, refused_q, last_q;
    logic [7:0]        byte_q;
    logic [LEN_W-1:0]  len_q;
    logic [3:0]        sts_q;
    logic [ADDR_W-1:0] put_addr;
    logic              beat, cls_bcast, cls_mcast, commit;

    assign beat     = s_valid && s_ready;
    assign put_addr = buf_q + ADDR_W'(len_q) - ADDR_W'(1);
    assign commit   = (state_q == ST_FIN) && (res_q == RES_OK);
    assign cur_desc = cur_q;
    assign sts_set  = sts_q;

    // Stream is open only while bytes are stored or drained.
    assign s_ready = (state_q == ST_RECV) || (state_q == ST_DROP);

    // Memory request generation for each access state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_q;
        mem_be    = 4'h0;
        mem_wdata = 32'h0;
        unique case (state_q)
            ST_RD_CTL:  mem_req = 1'b1;
            ST_RD_SIZE: begin mem_req = 1'b1; mem_addr = cur_q + ADDR_W'(4); end
            ST_RD_BUF:  begin mem_req = 1'b1; mem_addr = cur_q + ADDR_W'(8); end
            ST_PUT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {put_addr[ADDR_W-1:2], 2'b00};
                mem_be    = 4'b0001 << put_addr[1:0];
                mem_wdata = {4{byte_q}};
            end
            ST_WRB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = 4'hF;
                mem_wdata = {16'(len_q) + 16'(CRC_BYTES), 16'h0300};
            end
            default: ;
        endcase
    end

    // Frame sequencer, ring pointer and status pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            res_q     <= RES_NONE;
            base_q    <= '0;
            cur_q     <= '0;
            buf_q     <= '0;
            wrap_q    <= 1'b0;
            refused_q <= 1'b0;
            last_q    <= 1'b0;
            byte_q    <= '0;
            len_q     <= '0;
            sts_q     <= '0;
        end else begin
            sts_q <= '0;
            unique case (state_q)
                ST_IDLE: if (s_valid) begin
                    len_q     <= '0;
                    res_q     <= RES_NONE;
                    refused_q <= !rx_en;
                    state_q   <= rx_en ? ST_RD_CTL : ST_DROP;
                end
                ST_RD_CTL: if (mem_gnt)
                    state_q <= mem_rdata[31] ? ST_RD_SIZE : ST_DROP;
                ST_RD_SIZE: if (mem_gnt) begin
                    wrap_q  <= mem_rdata[15];
                    state_q <= ST_RD_BUF;
                end
                ST_RD_BUF: if (mem_gnt) begin
                    buf_q   <= mem_rdata[ADDR_W-1:0];
                    state_q <= ST_RECV;
                end
                ST_RECV: if (s_valid) begin
                    byte_q  <= s_data;
                    last_q  <= s_last;
                    len_q   <= len_q + LEN_W'(1);
                    state_q <= ST_PUT;
                end
                ST_PUT: if (mem_gnt) begin
                    if (!last_q)              state_q <= ST_RECV;
                    else if (len_q < MIN_LEN) begin
                        res_q   <= RES_RUNT;
                        state_q <= ST_FIN;
                    end else                  state_q <= ST_WRB;
                end
                ST_DROP: if (s_valid) begin
                    len_q <= len_q + LEN_W'(1);
                    if (s_last) begin
                        state_q <= ST_FIN;
                        if (refused_q)                        res_q <= RES_NONE;
                        else if (len_q + LEN_W'(1) < MIN_LEN) res_q <= RES_RUNT;
                        else                                  res_q <= RES_NODESC;
                    end
                end
                ST_WRB: if (mem_gnt) begin
                    cur_q   <= wrap_q ? base_q : cur_q + STEP;
                    res_q   <= RES_OK;
                    state_q <= ST_FIN;
                end
                ST_FIN: begin
                    unique case (res_q)
                        RES_OK, RES_RUNT: sts_q <= EV_DONE;
                        RES_NODESC:       sts_q <= EV_NODSC;
                        default:          sts_q <= '0;
                    endcase
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
            if (base_wr) begin
                base_q <= base_addr;
                cur_q  <= base_addr;
            end
        end
    end

    rxwb_classify u_cls (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (state_q == ST_IDLE),
        .beat     (beat && state_q == ST_RECV),
        .data     (s_data),
        .is_bcast (cls_bcast),
        .is_mcast (cls_mcast)
    );

    rxwb_stats #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_stats (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .frame_len (len_q),
        .is_bcast  (cls_bcast),
        .is_mcast  (cls_mcast),
        .frame_cnt (frame_cnt),
        .byte_cnt  (byte_cnt),
        .bcast_cnt (bcast_cnt),
        .mcast_cnt (mcast_cnt)
    );
endmodule

// File: rtl/rxwb_checker.sv
// Protocol and status properties for rxwb_engine, attached by bind.
module rxwb_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_be,
    input logic [31:0]       mem_wdata,
    input logic [3:0]        sts_set,
    input logic [CNT_W-1:0]  frame_cnt,
    input logic [CNT_W-1:0]  bcast_cnt,
    input logic [CNT_W-1:0]  mcast_cnt
);
    // No stream byte is taken while a memory access is pending.
    p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !s_ready);

    // A request and its address stay put until granted.
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // Data writes use exactly one byte lane.
    p_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be != 4'hF) |-> ($countones(mem_be) == 1));

    // Write-back word has the fixed low half, clear ownership, no runt length.
    p_wb_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be == 4'hF) |->
        (mem_wdata[15:0] == 16'h0300 && !mem_wdata[31] && mem_wdata[31:16] >= 16'd16));

    // Status events only in their defined pairs.
    p_evt_pairs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_set == 4'b0000 || sts_set == 4'b0011 || sts_set == 4'b1100));

    // The frame counter moves only together with a receive-done event.
    p_frame_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_cnt != $past(frame_cnt)) |->
        (frame_cnt == $past(frame_cnt) + CNT_W'(1) && sts_set == 4'b0011));

    // Class counters never exceed the frame count together.
    p_class_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, mcast_cnt} + {1'b0, bcast_cnt} <= {1'b0, frame_cnt}));
endmodule

bind rxwb_engine rxwb_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_ready   (s_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_gnt   (mem_gnt),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .sts_set   (sts_set),
    .frame_cnt (frame_cnt),
    .bcast_cnt (bcast_cnt),
    .mcast_cnt (mcast_cnt)
);

// File: tb/tb_rxwb_engine.sv
// Self-checking bench: directed corner frames plus a length/class sweep.
module tb_rxwb_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0;
    logic        base_wr = 1'b0;
    logic [31:0] base_addr = '0;
    logic        s_valid = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_last = 1'b0;
    logic        s_ready, mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, cur_desc;
    logic [3:0]  mem_be, sts_set;
    logic [31:0] frame_cnt, byte_cnt, bcast_cnt, mcast_cnt;

    logic [31:0] mem [0:1023];
    logic        gtog;
    int          n_chk = 0, n_fail = 0, wr_n = 0, ev_n = 0;
    logic [3:0]  ev_or = '0;
    int          e_frames = 0, e_bytes = 0, e_bc = 0, e_mc = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    rxwb_engine dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .base_wr(base_wr), .base_addr(base_addr),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .cur_desc(cur_desc), .sts_set(sts_set), .frame_cnt(frame_cnt),
        .byte_cnt(byte_cnt), .bcast_cnt(bcast_cnt), .mcast_cnt(mcast_cnt)
    );

    // Memory model: grant every other cycle, combinational read data.
    always @(posedge clk) gtog <= !rst_n ? 1'b0 : ~gtog;
    assign mem_gnt   = mem_req & gtog;
    assign mem_rdata = mem[mem_addr[11:2]];
    always @(posedge clk) if (mem_req && mem_we && mem_gnt) begin
        for (int l = 0; l < 4; l++)
            if (mem_be[l]) mem[mem_addr[11:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
        wr_n <= wr_n + 1;
    end

    // Collect status pulses away from the active edge.
    always @(negedge clk) if (sts_set != 4'h0) begin
        ev_or = ev_or | sts_set;
        ev_n  = ev_n + 1;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] fb(int kind, int seed, int i);
        logic [7:0] v = 8'(seed * 13 + i * 7 + 3);
        if (kind == 0 && i == 0) v = 8'h02;
        if (kind == 1 && i < 6) v = 8'hFF;
        if (kind == 2 && i == 0) v = 8'h01;
        if (kind == 3 && i < 5) v = 8'hFF;
        if (kind == 3 && i == 5) v = 8'hFE;
        return v;
    endfunction

    function automatic logic [7:0] rb(int a);
        return mem[a >> 2][8 * (a % 4) +: 8];
    endfunction

    task automatic setd(int a, logic [31:0] ctl, logic [31:0] sz, logic [31:0] bufa);
        mem[a >> 2] = ctl; mem[(a >> 2) + 1] = sz; mem[(a >> 2) + 2] = bufa;
    endtask

    task automatic send(int kind, int seed, int len);
        ev_or = '0; ev_n = 0;
        for (int i = 0; i < len; i++) begin
            s_valid = 1'b1; s_data = fb(kind, seed, i); s_last = (i == len - 1);
            while (!s_ready) @(negedge clk);
            @(negedge clk);
        end
        s_valid = 1'b0; s_last = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    // Accepted frame: check buffer, write-back word, pointer, counters, event.
    task automatic run_ok(int kind, int seed, int len, int da, int nxt, int bufa);
        send(kind, seed, len);
        e_frames++; e_bytes += len + 4;
        if (kind == 1) e_bc++;
        if (kind >= 2) e_mc++;
        for (int i = 0; i < len; i++) chk("R4 buffer byte", rb(bufa + i), fb(kind, seed, i));
        chk("R5 write-back word", mem[da >> 2], {16'(len + 4), 16'h0300});
        chk("R6 pointer step", cur_desc, 32'(nxt));
        chk("R8 frame count", frame_cnt, 32'(e_frames));
        chk("R8 byte count", byte_cnt, 32'(e_bytes));
        chk("R7 bcast count", bcast_cnt, 32'(e_bc));
        chk("R7 mcast count", mcast_cnt, 32'(e_mc));
        chk("R9 event value", ev_or, 4'b0011);
        chk("R9 event count", ev_n, 1);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        int w0;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        repeat (5) @(negedge clk);
        chk("R8 reset frame count", frame_cnt, 0);
        chk("R8 reset byte count", byte_cnt, 0);
        chk("R10 reset ready", s_ready, 0);
        chk("R6 reset pointer", cur_desc, 0);
        chk("R9 reset event", sts_set, 0);
        rst_n = 1'b1;
        @(negedge clk);
        base_addr = 32'h100; base_wr = 1'b1;
        @(negedge clk);
        base_wr = 1'b0;
        chk("R6 base load", cur_desc, 32'h100);

        setd(32'h100, 32'h8000_0000, 32'h0, 32'h400);
        setd(32'h120, 32'h8000_0000, 32'h0, 32'h480);
        setd(32'h140, 32'h8000_0000, 32'h8000, 32'h500);
        rx_en = 1'b1;
        run_ok(0, 1, 20, 32'h100, 32'h120, 32'h400);  // R7 unicast
        run_ok(1, 2, 12, 32'h120, 32'h140, 32'h480);  // R2 boundary, R7 broadcast
        run_ok(3, 3, 30, 32'h140, 32'h100, 32'h500);  // R6 wrap, R7 near-broadcast
        chk("R4 no byte past frame", rb(32'h500 + 30), 8'h00);

        // R2 runt with owned descriptor
        mem[32'h100 >> 2] = 32'h8000_0000;
        send(0, 4, 11);
        chk("R2 runt event", ev_or, 4'b0011);
        chk("R2 runt event count", ev_n, 1);
        chk("R2 runt no write-back", mem[32'h100 >> 2], 32'h8000_0000);
        chk("R2 runt pointer", cur_desc, 32'h100);
        chk("R2 runt counters", frame_cnt, 32'(e_frames));

        // R1 refused frame
        rx_en = 1'b0; w0 = wr_n;
        send(2, 5, 20);
        chk("R1 no memory write", wr_n, w0);
        chk("R1 no event", ev_n, 0);
        chk("R1 counters", byte_cnt, 32'(e_bytes));
        chk("R1 pointer", cur_desc, 32'h100);
        rx_en = 1'b1;

        // R3 descriptor not owned
        mem[32'h100 >> 2] = 32'h0; w0 = wr_n;
        send(0, 6, 20);
        chk("R3 no-descriptor event", ev_or, 4'b1100);
        chk("R3 event count", ev_n, 1);
        chk("R3 no memory write", wr_n, w0);
        chk("R3 counters", frame_cnt, 32'(e_frames));
        send(0, 7, 5);
        chk("R2 runt beats no-descriptor", ev_or, 4'b0011);
        chk("R2 runt not counted", frame_cnt, 32'(e_frames));

        // Sweep lengths and classes on a single self-wrapping descriptor.
        for (int len = 12; len <= 60; len++) begin
            setd(32'h100, 32'h8000_0000, 32'h8000, 32'h800);
            for (int k = 0; k < 32; k++) mem[(32'h800 >> 2) + k] = 32'hEEEE_EEEE;
            run_ok(len % 4, len, len, 32'h100, 32'h100, 32'h800);
            chk("R4 byte past frame untouched", rb(32'h800 + len), 8'hEE);
        end

        done = 1;
        summary();
    end
endmodule